// File: doc/BRIEF.md
# Variable-Page Translation Lookup Buffer

This block translates a 32-bit virtual address through a fully associative set of translation entries. Each entry has a tag word, a data word and an 8-bit tag ID. The tag word carries the effective page number, a page-size code and a valid flag. The data word carries the real page number, write-enable and execute-enable bits and a zone selector. The entry contents, the current process ID and the zone protection word arrive as plain inputs. Whatever loads and keeps them sits outside the block.

A request gives a virtual address, an access type and a privilege flag. All entries are compared in parallel, and the lowest-numbered matching entry wins. The page size of the winning entry sets how many low address bits pass straight through to the physical address. The zone selected by that entry can widen or remove its permissions, depending on privilege. The result is registered and presented one clock after the request, together with a protection-fault flag for the requested access.

A two-state controller sequences the result. State ST_IDLE means no result is on the outputs. State ST_RESULT means a registered result is valid. The transitions are as follows:
- ISSUE moves ST_IDLE to ST_RESULT when `req` is high.
- CHAIN keeps ST_RESULT when `req` stays high.
- DRAIN returns ST_RESULT to ST_IDLE when `req` is low.
- ST_IDLE holds while `req` is low.

Top module: `tlbv_lookup`

## Requirements
- R1: After reset (rst_n low at a clock edge), the controller is in ST_IDLE and `rsp_valid` is 0.
- R2: A request sampled at clock edge N drives `rsp_valid`=1 and its result after edge N, until edge N+1. An edge with `req` low leaves `rsp_valid`=0 after it.
- R3: The page-size code is tag bits [9:7]. Code s selects a page of 2^(10+2s) bytes (1 KiB up to 16 MiB). The compare mask is ~(page size − 1). The virtual address and the tag word are compared under this mask, so the effective page number lives in tag bits [31:10].
- R4: An entry whose valid flag (tag bit 6) is 0 never matches.
- R5: A nonzero tag ID matches only when it equals `pid`. A tag ID of 0 matches any `pid`.
- R6: When several entries match, the lowest index wins, and `rsp_idx` reports that index.
- R7: On a hit, `rsp_pa` takes the data-word bits selected by the page mask, and the virtual-address bits below the mask.
- R8: Data bits [7:4] pick zone z. The zone's 2-bit code sits in `zone_prot` bits [31−2z:30−2z], so zone 0 is the top two bits.
- R9: Zone code 0: user mode (`priv`=0) gets no permissions; privileged mode uses the entry's own permissions. Code 1: both modes use the entry's own permissions. Code 2: user mode uses the entry's own permissions; privileged mode gets all three. Code 3: both modes get all three.
- R10: `rsp_perm` is {read, write, execute}. The entry's own permissions are read=1, write=data bit 8 and execute=data bit 9.
- R11: `acc` is 0 for read, 1 for write, 2 for fetch and 3 for read. On a hit, `rsp_fault` is 1 when the permission for the access is absent.
- R12: On a miss, `rsp_hit`, `rsp_idx`, `rsp_pa`, `rsp_perm` and `rsp_fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Lookup request |
| va | input | 32 | Virtual address |
| acc | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 read |
| priv | input | 1 | 1 = privileged mode, 0 = user mode |
| pid | input | 8 | Current process ID |
| zone_prot | input | 32 | Sixteen 2-bit zone codes, zone 0 in the top bits |
| tag_words | input | N_ENT*32 | Tag words, entry i in bits [32i+31:32i] |
| data_words | input | N_ENT*32 | Data words, entry i in bits [32i+31:32i] |
| tid_bytes | input | N_ENT*8 | Tag IDs, entry i in bits [8i+7:8i] |
| rsp_valid | output | 1 | Registered result valid |
| rsp_hit | output | 1 | A matching entry was found |
| rsp_idx | output | $clog2(N_ENT) | Index of the winning entry |
| rsp_pa | output | 32 | Physical address |
| rsp_perm | output | 3 | {read, write, execute} permissions |
| rsp_fault | output | 1 | Requested access not permitted |

## Verification
The assertions check the following on every cycle:
- a request is answered at the next edge, and an idle edge clears `rsp_valid`;
- a fault never appears without a hit;
- a miss leaves every result field zero;
- a hit keeps the 1 KiB page offset of the requesting address;
- the chosen index really matches and no lower index matches;
- zone code 3 always grants all permissions.

Only the bench's scenarios can show the rest. These are the exact masked compare for each of the eight page sizes, the physical-address splice at each mask boundary, tag-ID wildcarding against a changing `pid`, and the full zone-code-by-privilege permission table. Each is checked against an independent reference model.

// File: rtl/tlbv_pkg.sv
package tlbv_pkg;
    localparam int AW          = 32;
    localparam int TID_W       = 8;
    localparam int SIZE_W      = 3;
    localparam int ZONE_W      = 4;
    localparam int MIN_PG_LOG2 = 10;
    localparam int SIZE_LSB    = 7;
    localparam int VALID_BIT   = 6;
    localparam int WR_BIT      = 8;
    localparam int EX_BIT      = 9;
    localparam int ZONE_LSB    = 4;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_READ2 = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        ZC_GUARD = 2'd0,
        ZC_ENTRY = 2'd1,
        ZC_SUPER = 2'd2,
        ZC_FULL  = 2'd3
    } zone_code_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    function automatic logic [AW-1:0] page_mask(input logic [SIZE_W-1:0] sz);
        logic [4:0] sh;
        sh = 5'(MIN_PG_LOG2) + 5'({sz, 1'b0});
        return {AW{1'b1}} << sh;
    endfunction
endpackage

// File: rtl/tlbv_entry_cmp.sv
module tlbv_entry_cmp
    import tlbv_pkg::*;
(
    input  logic [AW-1:0]    tag_word,
    input  logic [TID_W-1:0] tid,
    input  logic [TID_W-1:0] pid,
    input  logic [AW-1:0]    va,
    output logic             match
);
    logic [AW-1:0] msk;
    logic          addr_eq;
    logic          tid_ok;

    always_comb begin
        msk     = page_mask(tag_word[SIZE_LSB +: SIZE_W]);
        addr_eq = ((va & msk) == (tag_word & msk));
        tid_ok  = (tid == '0) || (tid == pid);
        match   = tag_word[VALID_BIT] && addr_eq && tid_ok;
    end
endmodule

// File: rtl/tlbv_first_hit.sv
module tlbv_first_hit #(
    parameter  int N  = 64,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  match_vec,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end

    logic [N-1:0] below;
    always_comb begin
        below = (N'(1) << idx) - N'(1);
        if (hit) begin
            AST_WINNER_MATCHES: assert (match_vec[idx]);              // R6
            AST_NONE_BELOW: assert ((match_vec & below) == '0);        // R6
        end else begin
            AST_MISS_NO_MATCH: assert (match_vec == '0);               // R6
        end
    end
endmodule

// File: rtl/tlbv_zone_perm.sv
module tlbv_zone_perm
    import tlbv_pkg::*;
(
    input  logic [AW-1:0] data_word,
    input  logic [AW-1:0] zone_prot,
    input  logic          priv,
    input  logic [1:0]    acc,
    output perm_t         perm,
    output logic          fault
);
    logic [ZONE_W-1:0] zone;
    zone_code_e        code;
    perm_t             own;
    perm_t             full;
    int                zsh;

    always_comb begin
        zone = data_word[ZONE_LSB +: ZONE_W];
        zsh  = (AW - 2) - 2 * int'(zone);
        code = zone_code_e'(zone_prot[zsh +: 2]);
        own  = '{rd: 1'b1, wr: data_word[WR_BIT], ex: data_word[EX_BIT]};
        full = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
        unique case (code)
            ZC_GUARD: perm = priv ? own : perm_t'(3'b000);
            ZC_ENTRY: perm = own;
            ZC_SUPER: perm = priv ? full : own;
            ZC_FULL:  perm = full;
            default:  perm = own;
        endcase
        unique case (acc_e'(acc))
            ACC_WRITE: fault = !perm.wr;
            ACC_FETCH: fault = !perm.ex;
            default:   fault = !perm.rd;
        endcase
    end

    always_comb begin
        if (code == ZC_FULL) begin
            AST_FULL_ZONE_GRANTS: assert (perm == perm_t'(3'b111));   // R9
        end
    end
endmodule

// File: rtl/tlbv_lookup.sv
module tlbv_lookup
    import tlbv_pkg::*;
#(
    parameter  int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req,
    input  logic [31:0]            va,
    input  logic [1:0]             acc,
    input  logic                   priv,
    input  logic [7:0]             pid,
    input  logic [31:0]            zone_prot,
    input  logic [N_ENT*32-1:0]    tag_words,
    input  logic [N_ENT*32-1:0]    data_words,
    input  logic [N_ENT*8-1:0]     tid_bytes,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic [IDX_W-1:0]       rsp_idx,
    output logic [31:0]            rsp_pa,
    output logic [2:0]             rsp_perm,
    output logic                   rsp_fault
);
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } state_e;

    state_e state_q, state_d;

    logic [N_ENT-1:0] match_vec;

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        tlbv_entry_cmp u_cmp (
            .tag_word (tag_words[g*AW +: AW]),
            .tid      (tid_bytes[g*TID_W +: TID_W]),
            .pid      (pid),
            .va       (va),
            .match    (match_vec[g])
        );
    end

    logic             c_hit;
    logic [IDX_W-1:0] c_idx;

    tlbv_first_hit #(.N(N_ENT)) u_sel (
        .match_vec (match_vec),
        .hit       (c_hit),
        .idx       (c_idx)
    );

    logic [AW-1:0] win_tag, win_data, win_mask, c_pa;

    always_comb begin
        win_tag  = tag_words[c_idx*AW +: AW];
        win_data = data_words[c_idx*AW +: AW];
        win_mask = page_mask(win_tag[SIZE_LSB +: SIZE_W]);
        c_pa     = (win_data & win_mask) | (va & ~win_mask);
    end

    perm_t c_perm;
    logic  c_fault;

    tlbv_zone_perm u_zone (
        .data_word (win_data),
        .zone_prot (zone_prot),
        .priv      (priv),
        .acc       (acc),
        .perm      (c_perm),
        .fault     (c_fault)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: ISSUE, CHAIN, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req)  state_d = ST_RESULT;
            ST_RESULT: if (!req) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit   <= 1'b0;
            rsp_idx   <= '0;
            rsp_pa    <= '0;
            rsp_perm  <= '0;
            rsp_fault <= 1'b0;
        end else if (req) begin
            rsp_hit   <= c_hit;
            rsp_idx   <= c_hit ? c_idx : '0;
            rsp_pa    <= c_hit ? c_pa : '0;
            rsp_perm  <= c_hit ? c_perm : 3'b000;
            rsp_fault <= c_hit && c_fault;
        end
    end

    assign rsp_valid = (state_q == ST_RESULT);

    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid);                                                 // R2
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid);                                               // R2
    AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> rsp_hit);                              // R11
    AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_perm == '0 && rsp_pa == '0 && rsp_idx == '0)); // R12
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (!rsp_hit || rsp_pa[9:0] == $past(va[9:0])));               // R7
endmodule

// File: tb/sim_tlbv_lookup.sv
`timescale 1ns/1ps
module sim_tlbv_lookup;
    localparam int N = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [31:0] va = '0;
    logic [1:0] acc = '0;
    logic priv = 1'b0;
    logic [7:0] pid = '0;
    logic [31:0] zone_prot = '0;
    logic [N*32-1:0] tag_words = '0;
    logic [N*32-1:0] data_words = '0;
    logic [N*8-1:0] tid_bytes = '0;
    logic rsp_valid, rsp_hit, rsp_fault;
    logic [5:0] rsp_idx;
    logic [31:0] rsp_pa;
    logic [2:0] rsp_perm;

    logic [31:0] tg [N];
    logic [31:0] dt [N];
    logic [7:0]  td [N];

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tlbv_lookup #(.N_ENT(N)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .va(va), .acc(acc), .priv(priv),
        .pid(pid), .zone_prot(zone_prot), .tag_words(tag_words),
        .data_words(data_words), .tid_bytes(tid_bytes), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_idx(rsp_idx), .rsp_pa(rsp_pa),
        .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
    );

    function automatic logic [31:0] mk_tag(input logic [31:0] epn, input logic [2:0] sz, input logic v);
        return (epn & 32'hFFFF_FC00) | (32'(sz) << 7) | (32'(v) << 6);
    endfunction

    function automatic logic [31:0] mk_data(input logic [31:0] rpn, input logic ex, input logic wr, input logic [3:0] z);
        return (rpn & 32'hFFFF_FC00) | (32'(ex) << 9) | (32'(wr) << 8) | (32'(z) << 4);
    endfunction

    function automatic logic [31:0] mask_of(input logic [2:0] sz);
        return 32'hFFFF_FFFF << (10 + 2 * int'(sz));
    endfunction

    task automatic clear_all();
        for (int i = 0; i < N; i++) begin
            tg[i] = '0; dt[i] = '0; td[i] = '0;
        end
    endtask

    task automatic pack();
        for (int i = 0; i < N; i++) begin
            tag_words[i*32 +: 32]  = tg[i];
            data_words[i*32 +: 32] = dt[i];
            tid_bytes[i*8 +: 8]    = td[i];
        end
    endtask

    task automatic ref_lookup(input logic [31:0] v, input logic [1:0] a, input logic p,
                              input logic [7:0] pd, input logic [31:0] z,
                              output logic e_hit, output logic [5:0] e_idx,
                              output logic [31:0] e_pa, output logic [2:0] e_perm,
                              output logic e_fault);
        logic found;
        logic [31:0] m, d;
        logic [1:0] code;
        logic rd, wr, ex;
        found = 0; e_hit = 0; e_idx = 0; e_pa = 0; e_perm = 0; e_fault = 0;
        for (int i = 0; i < N; i++) begin
            m = mask_of(tg[i][9:7]);
            if (!found && tg[i][6] && ((v & m) == (tg[i] & m)) && (td[i] == 0 || td[i] == pd)) begin
                found = 1;
                d = dt[i];
                e_hit = 1;
                e_idx = 6'(i);
                e_pa = (d & m) | (v & ~m);
                code = z[31 - 2*int'(d[7:4]) -: 2];
                rd = 1; wr = d[8]; ex = d[9];
                if (p) begin
                    if (code >= 2) begin rd = 1; wr = 1; ex = 1; end
                end else begin
                    if (code == 0) begin rd = 0; wr = 0; ex = 0; end
                    else if (code == 3) begin rd = 1; wr = 1; ex = 1; end
                end
                e_perm = {rd, wr, ex};
                e_fault = (a == 2'd1) ? !wr : (a == 2'd2) ? !ex : !rd;
            end
        end
    endtask

    task automatic run(input logic [31:0] v, input logic [1:0] a, input logic p,
                       input logic [7:0] pd, input logic [31:0] z, input string rq);
        logic e_hit, e_fault;
        logic [5:0] e_idx;
        logic [31:0] e_pa;
        logic [2:0] e_perm;
        @(negedge clk);
        pack();
        va = v; acc = a; priv = p; pid = pd; zone_prot = z; req = 1'b1;
        ref_lookup(v, a, p, pd, z, e_hit, e_idx, e_pa, e_perm, e_fault);
        @(negedge clk);
        req = 1'b0;
        checks++;
        if (rsp_valid !== 1'b1 || rsp_hit !== e_hit || rsp_idx !== e_idx ||
            rsp_pa !== e_pa || rsp_perm !== e_perm || rsp_fault !== e_fault) begin
            fails++;
            $display("FAIL %s: got v=%0b hit=%0b idx=%0d pa=%h perm=%b fault=%0b exp v=1 hit=%0b idx=%0d pa=%h perm=%b fault=%0b",
                     rq, rsp_valid, rsp_hit, rsp_idx, rsp_pa, rsp_perm, rsp_fault,
                     e_hit, e_idx, e_pa, e_perm, e_fault);
        end
    endtask

    task automatic check_idle(input string rq);
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL %s: rsp_valid got %0b exp 0", rq, rsp_valid);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] z;
        void'($urandom(32'd1234));
        clear_all();
        pack();
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: rsp_valid got %0b exp 0", rsp_valid);
        end
        rst_n = 1'b1;

        // R12, R4: all entries invalid -> miss
        tg[3] = mk_tag(32'h0001_2000, 3'd0, 1'b0);
        run(32'h0001_2000, 2'd0, 1'b1, 8'h00, 32'h5555_5555, "R4 invalid entry skipped / R12 miss");

        // R3: smallest page
        tg[5] = mk_tag(32'h0001_2400, 3'd0, 1'b1);
        dt[5] = mk_data(32'hABCD_E800, 1'b1, 1'b1, 4'd0);
        run(32'h0001_27FF, 2'd0, 1'b1, 8'h00, 32'h4000_0000, "R3 1KiB hit top of page");
        run(32'h0001_2800, 2'd0, 1'b1, 8'h00, 32'h4000_0000, "R3 1KiB miss next page");
        run(32'h0001_23FF, 2'd0, 1'b1, 8'h00, 32'h4000_0000, "R3 1KiB miss prev page");

        // R3, R7: largest page
        clear_all();
        tg[10] = mk_tag(32'h0500_0000, 3'd7, 1'b1);
        dt[10] = mk_data(32'h7700_0000, 1'b1, 1'b1, 4'd0);
        run(32'h05AB_CDEF, 2'd0, 1'b0, 8'h00, 32'h4000_0000, "R7 16MiB pa splice");
        run(32'h0600_0000, 2'd0, 1'b0, 8'h00, 32'h4000_0000, "R3 16MiB miss");
        // each size: hit at last byte, miss one past
        for (int s = 0; s < 8; s++) begin
            clear_all();
            tg[7] = mk_tag(32'h3000_0000, 3'(s), 1'b1);
            dt[7] = mk_data(32'hC5A5_5C00, 1'b0, 1'b1, 4'd0);
            run(32'h3000_0000 + ~mask_of(3'(s)), 2'd1, 1'b1, 8'h00, 32'h4000_0000, "R3 size edge hit / R7");
            run(32'h3000_0000 + ~mask_of(3'(s)) + 1, 2'd1, 1'b1, 8'h00, 32'h4000_0000, "R3 size edge miss");
        end

        // R6: lowest index wins
        clear_all();
        tg[30] = mk_tag(32'h0040_0000, 3'd2, 1'b1);
        dt[30] = mk_data(32'h1111_0000, 1'b1, 1'b1, 4'd0);
        tg[20] = mk_tag(32'h0040_0000, 3'd5, 1'b1);
        dt[20] = mk_data(32'h2220_0000, 1'b1, 1'b1, 4'd0);
        run(32'h0040_0123, 2'd0, 1'b1, 8'h00, 32'h4000_0000, "R6 lowest index wins");
        tg[20][6] = 1'b0;
        run(32'h0040_0123, 2'd0, 1'b1, 8'h00, 32'h4000_0000, "R6 R4 next after invalidate");

        // R5: tag IDs
        clear_all();
        tg[1] = mk_tag(32'h8000_0000, 3'd1, 1'b1);
        dt[1] = mk_data(32'h9000_0000, 1'b1, 1'b1, 4'd0);
        td[1] = 8'h33;
        run(32'h8000_0010, 2'd0, 1'b1, 8'h33, 32'h4000_0000, "R5 tid equal");
        run(32'h8000_0010, 2'd0, 1'b1, 8'h34, 32'h4000_0000, "R5 tid differs");
        td[1] = 8'h00;
        run(32'h8000_0010, 2'd0, 1'b1, 8'hC7, 32'h4000_0000, "R5 tid zero wildcard");

        // R8, R9, R10, R11: zone table on zone 3 and zone 0
        for (int zz = 0; zz < 2; zz++) begin
            for (int code = 0; code < 4; code++) begin
                for (int pm = 0; pm < 2; pm++) begin
                    for (int ac = 0; ac < 3; ac++) begin
                        for (int bits = 0; bits < 4; bits++) begin
                            clear_all();
                            tg[9] = mk_tag(32'h0020_0000, 3'd3, 1'b1);
                            dt[9] = mk_data(32'h00F0_0000, bits[1], bits[0], (zz == 0) ? 4'd3 : 4'd0);
                            z = (zz == 0) ? (32'(code) << 24) | 32'h00FF_FFFF
                                          : (32'(code) << 30) | 32'h0FFF_FFFF;
                            run(32'h0020_0ABC, 2'(ac), 1'(pm), 8'h00, z, "R9 R10 R11 R8 zone perms");
                        end
                    end
                end
            end
        end

        // R2: idle cycle
        check_idle("R2 no request clears valid");

        // random lookups
        for (int n = 0; n < 400; n++) begin
            int j;
            logic [31:0] m, v;
            for (int i = 0; i < N; i++) begin
                tg[i] = mk_tag($urandom, 3'($urandom_range(0, 7)), ($urandom_range(0, 3) != 0));
                dt[i] = mk_data($urandom, 1'($urandom), 1'($urandom), 4'($urandom));
                td[i] = ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom_range(1, 4));
            end
            j = $urandom_range(0, N - 1);
            m = mask_of(tg[j][9:7]);
            v = ($urandom_range(0, 4) == 0) ? $urandom : ((tg[j] & m) | ($urandom & ~m));
            run(v, 2'($urandom), 1'($urandom), 8'($urandom_range(0, 4)), $urandom,
                "R3 R5 R6 R7 R9 R11 random");
            if (n % 50 == 0) check_idle("R2 random idle");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule